// File: doc/BRIEF.md
# Half-Integer Sample Clock Generator

This block derives the timing for two audio converter paths from one fast system clock. Each path has its own 3-bit ratio code. The code sets how often a converter tick enable fires, measured in system cycles. The ratios are 1, 1.5, 2, 3, 4, 5.5 and 6. For the two half-integer ratios, the spacing between ticks alternates between the floor and the ceiling of the ratio, so the average is exact over every pair of ticks.

A shared mode bit sets how many ticks make one sample frame: 256 in normal mode and 272 in the 12 MHz mode. For each path the block gives a tick enable, a frame strobe and a left/right frame level. The strobe is one cycle long and fires on the tick that ends each frame. Everything runs on system-clock enables, and no derived clock is gated. A new code or mode is taken up by a path only at that path's next frame boundary.

Top module: `sample_rate_gen`

## Requirements
- R1: After reset the code in effect is 000 (divide by 1) and the mode in effect is normal. The left/right level is high, the error flag is low and the frame strobe is low.
- R2: Codes 000, 010, 011, 100 and 110 give ratios 1, 2, 3, 4 and 6. Ticks are evenly spaced by that many system cycles, and a frame lasts ratio × frame-length cycles.
- R3: Code 001 gives ratio 1.5, with tick gaps of 1 and 2 cycles. Code 101 gives ratio 5.5, with tick gaps of 5 and 6 cycles. The frame still lasts exactly ratio × frame-length cycles.
- R4: With the mode bit at 0, a frame is 256 ticks.
- R5: With the mode bit at 1, a frame is 272 ticks.
- R6: The frame strobe is high for exactly one system cycle per frame, and always in a cycle where the tick is high.
- R7: The left/right level is high during the first half of the ticks of a frame (128 or 136) and low during the second half. It changes only in the cycle after a tick.
- R8: Code 111 behaves as divide by 1. While it is in effect, that path's error flag is high.
- R9: A change of code or mode takes effect at the frame boundary that follows it. The frame in progress completes at its full old length, and the error flag changes only at a boundary.
- R10: The two paths take independent codes and share the mode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| usb_mode_i | input | 1 | Frame length select: 0 = 256 ticks, 1 = 272 ticks |
| adc_div_i | input | 3 | Ratio code for the ADC path |
| dac_div_i | input | 3 | Ratio code for the DAC path |
| adc_tick_o | output | 1 | ADC converter tick enable |
| adc_frame_o | output | 1 | ADC frame strobe |
| adc_lr_o | output | 1 | ADC left/right frame level |
| adc_cfg_err_o | output | 1 | ADC reserved code in effect |
| dac_tick_o | output | 1 | DAC converter tick enable |
| dac_frame_o | output | 1 | DAC frame strobe |
| dac_lr_o | output | 1 | DAC left/right frame level |
| dac_cfg_err_o | output | 1 | DAC reserved code in effect |

## Verification
The properties assume that the code and mode inputs are plain synchronous levels. They may change in any cycle, because the block only samples them on a strobe. The gap bound assumes that no ratio exceeds six cycles, which the 3-bit code guarantees. The stimulus changes inputs only just after a rising edge and holds each setting until both paths have finished a full frame under it. The two paths run different codes at the same time, and the settings cover every code, including the reserved one, in both modes.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int STEP_W = 4;

  typedef enum logic [2:0] {
    DIV_1    = 3'd0,
    DIV_1P5  = 3'd1,
    DIV_2    = 3'd2,
    DIV_3    = 3'd3,
    DIV_4    = 3'd4,
    DIV_5P5  = 3'd5,
    DIV_6    = 3'd6,
    DIV_RSVD = 3'd7
  } div_code_e;

  typedef struct packed {
    div_code_e code;
    logic      usb;
  } rate_cfg_t;

  // ratio expressed in half system cycles
  function automatic logic [STEP_W-1:0] half_steps(div_code_e c);
    case (c)
      DIV_1P5: half_steps = STEP_W'(3);
      DIV_2:   half_steps = STEP_W'(4);
      DIV_3:   half_steps = STEP_W'(6);
      DIV_4:   half_steps = STEP_W'(8);
      DIV_5P5: half_steps = STEP_W'(11);
      DIV_6:   half_steps = STEP_W'(12);
      default: half_steps = STEP_W'(2);
    endcase
  endfunction
endpackage

// File: rtl/half_step_div.sv
module half_step_div #(
  parameter int STEP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STEP_W-1:0] steps_i,
  output logic              tick_o
);
  localparam int SUM_W = STEP_W + 1;

  logic [STEP_W-1:0] acc_q, acc_d;
  logic [SUM_W-1:0]  sum;

  // accumulator advances two half-steps per system cycle
  always_comb begin
    sum    = {1'b0, acc_q} + SUM_W'(2);
    tick_o = (sum >= {1'b0, steps_i});
    acc_d  = tick_o ? STEP_W'(sum - {1'b0, steps_i}) : STEP_W'(sum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end
endmodule

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int FRAME_NORM = 256,
  parameter int FRAME_USB  = 272
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic usb_i,
  output logic frame_o,
  output logic lr_o
);
  localparam int FRAME_MAX = (FRAME_USB > FRAME_NORM) ? FRAME_USB : FRAME_NORM;
  localparam int CNT_W     = $clog2(FRAME_MAX);
  localparam logic [CNT_W-1:0] LAST_N = CNT_W'(FRAME_NORM - 1);
  localparam logic [CNT_W-1:0] LAST_U = CNT_W'(FRAME_USB - 1);
  localparam logic [CNT_W-1:0] HALF_N = CNT_W'(FRAME_NORM / 2 - 1);
  localparam logic [CNT_W-1:0] HALF_U = CNT_W'(FRAME_USB / 2 - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_idx, half_idx;
  logic             half_hit;
  logic             lr_q;

  always_comb begin
    last_idx = usb_i ? LAST_U : LAST_N;
    half_idx = usb_i ? HALF_U : HALF_N;
    frame_o  = tick_i && (cnt_q == last_idx);
    half_hit = tick_i && (cnt_q == half_idx);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lr_q  <= 1'b1;
    end else if (tick_i) begin
      cnt_q <= frame_o ? '0 : cnt_q + 1'b1;
      if (frame_o)       lr_q <= 1'b1;
      else if (half_hit) lr_q <= 1'b0;
    end
  end

  assign lr_o = lr_q;
endmodule

// File: rtl/rate_chain.sv
module rate_chain
  import clkgen_pkg::*;
#(
  parameter int FRAME_NORM = 256,
  parameter int FRAME_USB  = 272
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] code_i,
  input  logic       usb_i,
  output logic       tick_o,
  output logic       frame_o,
  output logic       lr_o,
  output logic       cfg_err_o
);
  rate_cfg_t         act_q;
  logic [STEP_W-1:0] steps;

  // configuration is sampled only on the frame strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      act_q <= '{code: DIV_1, usb: 1'b0};
    else if (frame_o) act_q <= '{code: div_code_e'(code_i), usb: usb_i};
  end

  assign steps     = half_steps(act_q.code);
  assign cfg_err_o = (act_q.code == DIV_RSVD);

  half_step_div #(.STEP_W(STEP_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .steps_i (steps),
    .tick_o  (tick_o)
  );

  frame_seq #(.FRAME_NORM(FRAME_NORM), .FRAME_USB(FRAME_USB)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_o),
    .usb_i   (act_q.usb),
    .frame_o (frame_o),
    .lr_o    (lr_o)
  );
endmodule

// File: rtl/sample_rate_gen.sv
module sample_rate_gen #(
  parameter int FRAME_NORM = 256,
  parameter int FRAME_USB  = 272
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       usb_mode_i,
  input  logic [2:0] adc_div_i,
  input  logic [2:0] dac_div_i,
  output logic       adc_tick_o,
  output logic       adc_frame_o,
  output logic       adc_lr_o,
  output logic       adc_cfg_err_o,
  output logic       dac_tick_o,
  output logic       dac_frame_o,
  output logic       dac_lr_o,
  output logic       dac_cfg_err_o
);
  localparam int NUM_CH = 2;

  logic [2:0] code_w [NUM_CH];
  logic       tick_w [NUM_CH];
  logic       frame_w[NUM_CH];
  logic       lr_w   [NUM_CH];
  logic       err_w  [NUM_CH];

  assign code_w[0] = adc_div_i;
  assign code_w[1] = dac_div_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    rate_chain #(.FRAME_NORM(FRAME_NORM), .FRAME_USB(FRAME_USB)) u_chain (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .code_i    (code_w[g]),
      .usb_i     (usb_mode_i),
      .tick_o    (tick_w[g]),
      .frame_o   (frame_w[g]),
      .lr_o      (lr_w[g]),
      .cfg_err_o (err_w[g])
    );
  end

  assign adc_tick_o    = tick_w[0];
  assign adc_frame_o   = frame_w[0];
  assign adc_lr_o      = lr_w[0];
  assign adc_cfg_err_o = err_w[0];
  assign dac_tick_o    = tick_w[1];
  assign dac_frame_o   = frame_w[1];
  assign dac_lr_o      = lr_w[1];
  assign dac_cfg_err_o = err_w[1];
endmodule

// File: rtl/sample_rate_gen_chk.sv
module sample_rate_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       usb_mode_i,
  input logic [2:0] adc_div_i,
  input logic [2:0] dac_div_i,
  input logic       adc_tick_o,
  input logic       adc_frame_o,
  input logic       adc_lr_o,
  input logic       adc_cfg_err_o,
  input logic       dac_tick_o,
  input logic       dac_frame_o,
  input logic       dac_lr_o,
  input logic       dac_cfg_err_o
);
  logic [3:0] adc_gap_q, dac_gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adc_gap_q <= '0;
      dac_gap_q <= '0;
    end else begin
      adc_gap_q <= adc_tick_o ? 4'd0 : ((adc_gap_q == 4'hf) ? adc_gap_q : adc_gap_q + 4'd1);
      dac_gap_q <= dac_tick_o ? 4'd0 : ((dac_gap_q == 4'hf) ? dac_gap_q : dac_gap_q + 4'd1);
    end
  end

  // R2 R3
  adc_gap_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) adc_gap_q <= 4'd5);
  // R2 R3
  dac_gap_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) dac_gap_q <= 4'd5);
  // R6
  adc_frame_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) adc_frame_o |-> adc_tick_o);
  // R6
  dac_frame_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) dac_frame_o |-> dac_tick_o);
  // R6
  adc_frame_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) adc_frame_o |=> !adc_frame_o);
  // R6
  dac_frame_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) dac_frame_o |=> !dac_frame_o);
  // R7
  adc_lr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !adc_tick_o |=> $stable(adc_lr_o));
  // R7
  dac_lr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !dac_tick_o |=> $stable(dac_lr_o));
  // R7
  adc_lr_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(adc_lr_o) |-> $past(adc_frame_o));
  // R7
  dac_lr_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(dac_lr_o) |-> $past(dac_frame_o));
  // R9
  adc_err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !adc_frame_o |=> $stable(adc_cfg_err_o));
  // R9
  dac_err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !dac_frame_o |=> $stable(dac_cfg_err_o));
endmodule

bind sample_rate_gen sample_rate_gen_chk u_chk (.*);

// File: tb/sim_sample_rate_gen.sv
module sim_sample_rate_gen;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       usb_mode = 1'b0;
  logic [2:0] adc_div = 3'd0;
  logic [2:0] dac_div = 3'd0;
  logic adc_tick, adc_frame, adc_lr, adc_err;
  logic dac_tick, dac_frame, dac_lr, dac_err;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int len;
    int gmin;
    int gmax;
    int hi;
    bit err;
    bit carry;
    bit half;
    bit usb;
  } exp_t;

  exp_t q_adc[$];
  exp_t q_dac[$];
  exp_t cur[2];

  int cyc[2], gap[2], gmin[2], gmax[2], hi[2];
  bit primed[2];

  always #10 clk = ~clk;

  sample_rate_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .usb_mode_i(usb_mode),
    .adc_div_i(adc_div), .dac_div_i(dac_div),
    .adc_tick_o(adc_tick), .adc_frame_o(adc_frame), .adc_lr_o(adc_lr), .adc_cfg_err_o(adc_err),
    .dac_tick_o(dac_tick), .dac_frame_o(dac_frame), .dac_lr_o(dac_lr), .dac_cfg_err_o(dac_err)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expectations from R2 R3 R4 R5 R7 R8
  function automatic exp_t mk_exp(int code, bit m, bit carry);
    exp_t e;
    int n2, f;
    case (code)
      1: n2 = 3;  2: n2 = 4;  3: n2 = 6;
      4: n2 = 8;  5: n2 = 11; 6: n2 = 12;
      default: n2 = 2;
    endcase
    f       = m ? 272 : 256;
    e.len   = n2 * f / 2;
    e.gmin  = n2 / 2;
    e.gmax  = (n2 + 1) / 2;
    e.hi    = f / 2;
    e.err   = (code == 7);
    e.carry = carry;
    e.half  = (code == 1) || (code == 5);
    e.usb   = m;
    return e;
  endfunction

  task automatic compare(int ch, exp_t e);
    string base, sfx;
    sfx  = (ch == 1) ? " R10" : "";
    base = e.carry ? "R9" : {e.half ? "R3" : "R2", e.usb ? "/R5" : "/R4"};
    chk({base, sfx}, "frame cycles", cyc[ch], e.len);
    chk({e.half ? "R3" : "R2", sfx}, "min gap", gmin[ch], e.gmin);
    chk({e.half ? "R3" : "R2", sfx}, "max gap", gmax[ch], e.gmax);
    chk({"R7", sfx}, "ticks with lr high", hi[ch], e.hi);
    chk({"R8", sfx}, "cfg_err", int'(primed[ch] ? e.err : 1'b0), int'(e.err));
  endtask

  task automatic mon_ch(int ch, logic tk, logic fr, logic lr, logic er);
    exp_t e;
    cyc[ch]++;
    gap[ch]++;
    if (tk) begin
      if (gap[ch] < gmin[ch]) gmin[ch] = gap[ch];
      if (gap[ch] > gmax[ch]) gmax[ch] = gap[ch];
      gap[ch] = 0;
      if (lr) hi[ch]++;
    end
    if (fr) begin
      chk("R6", "tick at strobe", int'(tk), 1);
      if (primed[ch]) begin
        if (ch == 0 && q_adc.size() > 0) begin
          e = q_adc.pop_front();
          compare(ch, e);
          chk("R8", "adc err flag", int'(er), int'(e.err));
        end else if (ch == 1 && q_dac.size() > 0) begin
          e = q_dac.pop_front();
          compare(ch, e);
          chk("R8 R10", "dac err flag", int'(er), int'(e.err));
        end
      end
      primed[ch] = 1'b1;
      cyc[ch] = 0; gmin[ch] = 1000; gmax[ch] = 0; hi[ch] = 0;
    end
  endtask

  // monitor: samples away from the active edge
  always @(negedge clk) begin
    if (rst_ni) begin
      mon_ch(0, adc_tick, adc_frame, adc_lr, adc_err);
      mon_ch(1, dac_tick, dac_frame, dac_lr, dac_err);
    end
  end

  // driver: pushes the frame in progress (old setting) then the first full new frame
  task automatic run_cfg(int a, int d, bit m);
    exp_t na, nd;
    @(posedge clk);
    #1;
    na = mk_exp(a, m, 1'b0);
    nd = mk_exp(d, m, 1'b0);
    q_adc.push_back(cur[0]);
    q_adc.push_back(na);
    q_dac.push_back(cur[1]);
    q_dac.push_back(nd);
    adc_div  = 3'(a);
    dac_div  = 3'(d);
    usb_mode = m;
    while (q_adc.size() > 0 || q_dac.size() > 0) @(negedge clk);
    cur[0] = na; cur[0].carry = 1'b1;
    cur[1] = nd; cur[1].carry = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      cyc[i] = 0; gap[i] = 0; gmin[i] = 1000; gmax[i] = 0; hi[i] = 0; primed[i] = 1'b0;
    end
    cur[0] = mk_exp(0, 1'b0, 1'b1);
    cur[1] = mk_exp(0, 1'b0, 1'b1);
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "adc_lr", int'(adc_lr), 1);
    chk("R1", "dac_lr", int'(dac_lr), 1);
    chk("R1", "adc_cfg_err", int'(adc_err), 0);
    chk("R1", "dac_cfg_err", int'(dac_err), 0);
    chk("R1", "adc_frame", int'(adc_frame), 0);
    chk("R1", "adc_tick divide by 1", int'(adc_tick), 1);
    while (!(primed[0] && primed[1])) @(negedge clk);
    run_cfg(0, 0, 1'b0);
    run_cfg(1, 5, 1'b0);
    run_cfg(2, 3, 1'b0);
    run_cfg(4, 6, 1'b0);
    run_cfg(5, 1, 1'b1);
    run_cfg(6, 7, 1'b1);
    run_cfg(7, 2, 1'b0);
    run_cfg(3, 4, 1'b1);
    run_cfg(0, 6, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule